// File: doc/BRIEF.md
# Serial Receiver with Tagged Errors

This block turns an asynchronous serial line into a stream of 10-bit receive words. An oversampling tick (`tick16`), sixteen pulses per bit time, drives all of its timing. It supports several character formats chosen by a 3-bit format field: plain 8-bit, 7-bit with parity, 8-bit with parity, and two 9-bit formats. A 2-bit stop-length field and an odd/even parity select complete the format. Each received character leaves as one word. Data sits in bits 7:0, bit 8 is the parity-error flag (or the ninth data bit in the 9-bit formats), and bit 9 is the framing-error flag. Any status a consumer needs therefore travels with the character it belongs to.

The line passes through a synchroniser. A loopback control can switch the receiver input from the external pin to the local transmit line. A receive-enable input holds the receiver idle. Words leave on a valid/ready stream. `out_valid` stays high and `out_word` stays unchanged until `out_ready` is seen high on a clock edge. The stage holds one word. If a character completes while a word is still waiting and `out_ready` is low, the new character is discarded and the waiting word is kept. If `out_ready` is high in that same cycle, the new word replaces the accepted one. The format inputs are expected to stay stable while a character is in flight.

Top module: `serial_rx_tagger`

## Requirements
- R1: Format 3'b001 receives 8 data bits, least significant bit first, into word bits 7:0 with bit 8 cleared. Format codes 3'b000, 3'b010 and 3'b110 behave the same way.
- R2: Format 3'b011 receives 7 data bits and then a parity bit. Word bits 6:0 carry the data, word bit 7 is always 0, and word bit 8 is the parity-error flag.
- R3: Format 3'b111 receives 8 data bits and then a parity bit, and word bit 8 is the parity-error flag. With `par_odd`=0 the data and parity bits together must hold an even number of ones. With `par_odd`=1 they must hold an odd number. A mismatch sets the flag.
- R4: Formats 3'b100 and 3'b101 receive 9 bits. The ninth received bit goes to word bit 8.
- R5: A low level seen on a tick is only taken as a start bit if the line is still low 8 ticks later. A shorter low pulse pushes nothing. Each later bit is sampled 16 ticks after the previous one.
- R6: If the line is low where the first stop bit is sampled, word bit 9 is set. A break (line low through a whole character) gives the word 10'h200 in format 3'b001. After a framing error the receiver looks for a new start bit only once the line has gone high.
- R7: The first stop bit is sampled 12 ticks after the last data or parity sample when `stop_sel`=2'b00, and 16 ticks after it otherwise. After that sample the receiver waits a further 0, 0, 8 or 16 ticks before hunting again, for `stop_sel` 2'b00, 2'b01, 2'b10 and 2'b11.
- R8: While `rx_en` is low the line is ignored and no word is produced.
- R9: With `loop_en`=1 the receiver takes its input from `tx_loop` and ignores `rx_pin`. With `loop_en`=0 it takes its input from `rx_pin` and ignores `tx_loop`.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` stays unchanged. A character that completes in that state is dropped.
- R11: `out_valid` is low after reset. It rises on the tick edge at which the first stop bit is sampled. For format 3'b001 with `stop_sel`=2'b01 that is 153 ticks after the tick edge that first registers the start bit at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling tick, 16 per bit time, one clock wide |
| rx_en | input | 1 | Receive enable |
| loop_en | input | 1 | Selects the local transmit line as the receiver input |
| fmt_sel | input | 3 | Character format code |
| stop_sel | input | 2 | Stop-length code |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rx_pin | input | 1 | External serial input, idle high |
| tx_loop | input | 1 | Local transmit line used in loopback |
| out_valid | output | 1 | Receive word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | 10 | {framing error, parity error or ninth bit, data[7:0]} |

## Verification
A level driven onto the line just before tick edge T0 reaches the receiver one clock after T0. Start detection happens at T1 and the start is confirmed at T9. Data sample k falls at T25+16k, and the first stop bit is sampled 16 ticks after the last data or parity sample (12 ticks for the half-bit setting). The word appears on that same edge. The bench changes inputs and reads `out_valid` only on falling clock edges, each one counted against the tick stream. The timing test reads `out_valid` just before and just after tick 153. Every other scenario waits past its last expected stop sample, plus any extra stop wait, before it compares the captured words and their count.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam logic [2:0] FMT_8N = 3'b001;
  localparam logic [2:0] FMT_7P = 3'b011;
  localparam logic [2:0] FMT_8P = 3'b111;
  localparam logic [2:0] FMT_9B = 3'b100;
  localparam logic [2:0] FMT_8W = 3'b101;

  localparam logic [1:0] STP_HALF     = 2'b00;
  localparam logic [1:0] STP_ONE      = 2'b01;
  localparam logic [1:0] STP_ONE_HALF = 2'b10;
  localparam logic [1:0] STP_TWO      = 2'b11;

  localparam int MAX_BITS = 9;
  localparam int WORD_W   = 10;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_BITS, RX_STOP, RX_GAP, RX_LOWWAIT
  } rx_state_e;

  // count of bit slots between start and first stop
  function automatic logic [3:0] bits_after_start(input logic [2:0] fmt);
    case (fmt)
      FMT_8P, FMT_9B, FMT_8W: return 4'd9;
      default:                return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic loop_src,
  input  logic loop_en,
  output logic line
);
  localparam int NST = (STAGES < 2) ? 2 : STAGES;

  logic             raw;
  logic [NST-1:0]   chain;

  assign raw  = loop_en ? loop_src : pin;
  assign line = chain[NST-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[NST-2:0], raw};
  end

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                enable,
  input  logic                line,
  input  logic [2:0]          fmt,
  input  logic [1:0]          stop_sel,
  output logic                push,
  output logic                fe,
  output logic [MAX_BITS-1:0] shreg
);
  localparam int HALF  = OVERSAMPLE / 2;
  localparam int QUART = OVERSAMPLE / 4;
  localparam int CW    = $clog2(OVERSAMPLE + 1);
  localparam int IW    = $clog2(MAX_BITS + 1);

  rx_state_e      st;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  last;
  logic [CW-1:0]  stop_pos;
  logic [CW-1:0]  gap_len;
  logic [IW-1:0]  idx;
  logic [IW-1:0]  nbits;
  logic           hit;

  assign nbits    = IW'(bits_after_start(fmt));
  assign stop_pos = (stop_sel == STP_HALF) ? CW'(HALF + QUART) : CW'(OVERSAMPLE);

  always_comb begin
    case (stop_sel)
      STP_ONE_HALF: gap_len = CW'(HALF);
      STP_TWO:      gap_len = CW'(OVERSAMPLE);
      default:      gap_len = '0;
    endcase
  end

  always_comb begin
    case (st)
      RX_START: last = CW'(HALF - 1);
      RX_BITS:  last = CW'(OVERSAMPLE - 1);
      RX_STOP:  last = stop_pos - 1'b1;
      RX_GAP:   last = gap_len - 1'b1;
      default:  last = '0;
    endcase
  end

  assign hit  = tick && (cnt == last);
  assign push = enable && (st == RX_STOP) && hit;
  assign fe   = !line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
    end else if (!enable) begin
      st  <= RX_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        RX_IDLE: begin
          if (tick && !line) begin
            st  <= RX_START;
            cnt <= '0;
          end
        end
        RX_START: begin
          if (hit) begin
            cnt <= '0;
            if (!line) begin
              st    <= RX_BITS;
              idx   <= '0;
              shreg <= '0;
            end else begin
              st <= RX_IDLE;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_BITS: begin
          if (hit) begin
            shreg[idx] <= line;
            cnt        <= '0;
            if (idx == nbits - 1'b1) st <= RX_STOP;
            else                     idx <= idx + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (hit) begin
            cnt <= '0;
            if (!line)              st <= RX_LOWWAIT;
            else if (gap_len == '0) st <= RX_IDLE;
            else                    st <= RX_GAP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_GAP: begin
          if (hit) begin
            cnt <= '0;
            st  <= RX_IDLE;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_LOWWAIT: begin
          if (line) st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R5: bit sampling only begins after a start level confirmed low
  p_start_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_BITS && $past(st) == RX_START) |-> !$past(line));

  // R6: after a framing error, no new hunt while the line stays low
  p_fe_hunt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fe) |=> (st == RX_LOWWAIT || !enable || $past(line) == 1'b0 && line));

endmodule

// File: rtl/rx_word_pack.sv
module rx_word_pack
  import serial_rx_pkg::*;
(
  input  logic [2:0]          fmt,
  input  logic                par_odd,
  input  logic [MAX_BITS-1:0] shreg,
  input  logic                fe,
  output logic [WORD_W-1:0]   word
);
  always_comb begin
    word    = '0;
    word[9] = fe;
    case (fmt)
      FMT_7P: begin
        word[6:0] = shreg[6:0];
        word[8]   = (^shreg[7:0]) ^ par_odd;
      end
      FMT_8P: begin
        word[7:0] = shreg[7:0];
        word[8]   = (^shreg[8:0]) ^ par_odd;
      end
      FMT_9B, FMT_8W: begin
        word[7:0] = shreg[7:0];
        word[8]   = shreg[8];
      end
      default: word[7:0] = shreg[7:0];
    endcase
  end
endmodule

// File: rtl/rx_out_stage.sv
module rx_out_stage
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] word_in,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] word
);
  logic take;
  assign take = push && (!valid || ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      word  <= '0;
    end else if (take) begin
      valid <= 1'b1;
      word  <= word_in;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R10: a held word neither vanishes nor changes under back-pressure
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(word)));

endmodule

// File: rtl/serial_rx_tagger.sv
module serial_rx_tagger
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        rx_en,
  input  logic        loop_en,
  input  logic [2:0]  fmt_sel,
  input  logic [1:0]  stop_sel,
  input  logic        par_odd,
  input  logic        rx_pin,
  input  logic        tx_loop,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [9:0]  out_word
);
  logic                line;
  logic                push;
  logic                fe;
  logic [MAX_BITS-1:0] shreg;
  logic [WORD_W-1:0]   packed_word;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(rx_pin), .loop_src(tx_loop),
    .loop_en(loop_en), .line(line)
  );

  rx_frame_fsm #(.OVERSAMPLE(OVERSAMPLE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .enable(rx_en), .line(line),
    .fmt(fmt_sel), .stop_sel(stop_sel), .push(push), .fe(fe), .shreg(shreg)
  );

  rx_word_pack u_pack (
    .fmt(fmt_sel), .par_odd(par_odd), .shreg(shreg), .fe(fe), .word(packed_word)
  );

  rx_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .push(push), .word_in(packed_word),
    .ready(out_ready), .valid(out_valid), .word(out_word)
  );

  // R8: with reception off and nothing pending, nothing appears
  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !out_valid) |=> !out_valid);

  // R2: seven-bit format never reports a set bit 7
  p_msb7_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && fmt_sel == FMT_7P) |-> !out_word[7]);

  // R1: plain eight-bit format leaves bit 8 clear
  p_plain_b8_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && fmt_sel == FMT_8N) |-> !out_word[8]);

endmodule

// File: tb/sim_serial_rx_tagger.sv
module sim_serial_rx_tagger;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] tcnt = 2'd0;
  logic tick16;
  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign tick16 = (tcnt == 2'd3);

  logic       rx_en = 1'b1, loop_en = 1'b0, par_odd = 1'b0;
  logic [2:0] fmt_sel = 3'b001;
  logic [1:0] stop_sel = 2'b01;
  logic       rx_pin = 1'b1, tx_loop = 1'b1, out_ready = 1'b1;
  logic       out_valid;
  logic [9:0] out_word;

  serial_rx_tagger u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en), .loop_en(loop_en),
    .fmt_sel(fmt_sel), .stop_sel(stop_sel), .par_odd(par_odd), .rx_pin(rx_pin),
    .tx_loop(tx_loop), .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  int n_checks = 0, n_fail = 0, cap_n = 0;
  logic [9:0] cap [0:63];
  bit done = 0;

  always @(posedge clk)
    if (rst_n && out_valid && out_ready && cap_n < 64) begin
      cap[cap_n] = out_word;
      cap_n = cap_n + 1;
    end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!tick16) @(negedge clk);
    end
  endtask

  task automatic drive(input bit sel, input logic v);
    if (sel) tx_loop = v; else rx_pin = v;
  endtask

  task automatic send_frame(input bit sel, input logic [8:0] pay, input int nb,
                            input logic stop_v, input int stop_t);
    drive(sel, 1'b0); wait_ticks(16);
    for (int i = 0; i < nb; i++) begin
      drive(sel, pay[i]); wait_ticks(16);
    end
    drive(sel, stop_v); wait_ticks(stop_t);
    drive(sel, 1'b1);
  endtask

  task automatic expect_one(input string req, input int base, input logic [9:0] exp);
    check(cap_n - base == 1, {req, " count"}, cap_n - base, 1);
    if (cap_n > base) check(cap[base] == exp, req, cap[base], exp);
  endtask

  task automatic expect_two(input string req, input int base, input logic [9:0] e0, input logic [9:0] e1);
    check(cap_n - base == 2, {req, " count"}, cap_n - base, 2);
    if (cap_n > base + 1) begin
      check(cap[base] == e0, {req, " first"}, cap[base], e0);
      check(cap[base+1] == e1, {req, " second"}, cap[base+1], e1);
    end
  endtask

  task automatic one_frame(input string req, input logic [8:0] pay, input int nb, input logic [9:0] exp);
    int b;
    b = cap_n;
    wait_ticks(1);
    send_frame(0, pay, nb, 1'b1, 16);
    wait_ticks(40);
    expect_one(req, b, exp);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R11 reset valid", out_valid, 0);
  endtask

  task automatic t_plain();
    fmt_sel = 3'b001; one_frame("R1 8N A5", 9'h0A5, 8, 10'h0A5);
    fmt_sel = 3'b000; one_frame("R1 code000 3C", 9'h03C, 8, 10'h03C);
    fmt_sel = 3'b001;
  endtask

  task automatic t_seven();
    fmt_sel = 3'b011; par_odd = 0;
    one_frame("R2 7P good parity", 9'h0B1, 8, 10'h031);
    one_frame("R2 7P bad parity", 9'h031, 8, 10'h131);
    fmt_sel = 3'b001;
  endtask

  task automatic t_eight_par();
    fmt_sel = 3'b111; par_odd = 0;
    one_frame("R3 even good", 9'h05A, 9, 10'h05A);
    one_frame("R3 even bad", 9'h15A, 9, 10'h15A);
    par_odd = 1;
    one_frame("R3 odd good", 9'h15A, 9, 10'h05A);
    one_frame("R3 odd good b", 9'h05B, 9, 10'h05B);
    par_odd = 0; fmt_sel = 3'b001;
  endtask

  task automatic t_nine();
    fmt_sel = 3'b100; one_frame("R4 nine-bit", 9'h1C5, 9, 10'h1C5);
    fmt_sel = 3'b101; one_frame("R4 wake format", 9'h0C5, 9, 10'h0C5);
    fmt_sel = 3'b001;
  endtask

  task automatic t_glitch();
    int b;
    b = cap_n;
    wait_ticks(1);
    drive(0, 1'b0); wait_ticks(4); drive(0, 1'b1);
    wait_ticks(200);
    check(cap_n == b, "R5 short low ignored", cap_n - b, 0);
    one_frame("R5 frame after glitch", 9'h05C, 8, 10'h05C);
  endtask

  task automatic t_framing();
    int b;
    b = cap_n;
    wait_ticks(1);
    send_frame(0, 9'h055, 8, 1'b0, 16);
    wait_ticks(40);
    expect_one("R6 bad stop", b, 10'h255);
    b = cap_n;
    drive(0, 1'b0); wait_ticks(16 * 14); drive(0, 1'b1);
    wait_ticks(40);
    expect_one("R6 break", b, 10'h200);
    one_frame("R6 after break", 9'h0A3, 8, 10'h0A3);
  endtask

  task automatic pair(input string req, input logic [1:0] ss, input logic [8:0] p0,
                      input logic [8:0] p1, input int st, input logic [9:0] e0, input logic [9:0] e1);
    int b;
    stop_sel = ss; b = cap_n;
    wait_ticks(1);
    send_frame(0, p0, 8, 1'b1, st);
    send_frame(0, p1, 8, 1'b1, st);
    wait_ticks(60);
    expect_two(req, b, e0, e1);
  endtask

  task automatic t_stop();
    pair("R7 two-stop gap", 2'b11, 9'h036, 9'h036, 16, 10'h036, 10'h09B);
    pair("R7 one-stop", 2'b01, 9'h036, 9'h036, 16, 10'h036, 10'h036);
    pair("R7 half-stop", 2'b00, 9'h06C, 9'h093, 8, 10'h06C, 10'h093);
    pair("R7 one-and-half", 2'b10, 9'h036, 9'h0E4, 24, 10'h036, 10'h0E4);
    stop_sel = 2'b01;
  endtask

  task automatic t_enable();
    int b;
    b = cap_n; rx_en = 0;
    wait_ticks(1);
    send_frame(0, 9'h0A5, 8, 1'b1, 16);
    wait_ticks(40);
    check(cap_n == b, "R8 disabled count", cap_n - b, 0);
    check(out_valid == 1'b0, "R8 disabled valid", out_valid, 0);
    rx_en = 1;
    one_frame("R8 re-enabled", 9'h05C, 8, 10'h05C);
  endtask

  task automatic t_loop();
    int b;
    loop_en = 1; b = cap_n;
    wait_ticks(1);
    send_frame(1, 9'h096, 8, 1'b1, 16); wait_ticks(40);
    expect_one("R9 loop from tx", b, 10'h096);
    b = cap_n;
    send_frame(0, 9'h011, 8, 1'b1, 16); wait_ticks(40);
    check(cap_n == b, "R9 pin ignored in loop", cap_n - b, 0);
    loop_en = 0; b = cap_n;
    send_frame(1, 9'h022, 8, 1'b1, 16); wait_ticks(40);
    check(cap_n == b, "R9 tx ignored without loop", cap_n - b, 0);
  endtask

  task automatic t_backpressure();
    int b;
    b = cap_n; out_ready = 0;
    wait_ticks(1);
    send_frame(0, 9'h021, 8, 1'b1, 16);
    send_frame(0, 9'h042, 8, 1'b1, 16);
    wait_ticks(40);
    check(out_valid == 1'b1, "R10 held valid", out_valid, 1);
    check(out_word == 10'h021, "R10 held word", out_word, 10'h021);
    out_ready = 1;
    repeat (4) @(negedge clk);
    expect_one("R10 accepted, second dropped", b, 10'h021);
    check(out_valid == 1'b0, "R10 valid after accept", out_valid, 0);
  endtask

  task automatic t_timing();
    fmt_sel = 3'b001; stop_sel = 2'b01;
    wait_ticks(1);
    fork
      send_frame(0, 9'h04D, 8, 1'b1, 16);
      begin
        wait_ticks(153);
        check(out_valid == 1'b0, "R11 before stop tick", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R11 at stop tick", out_valid, 1);
        check(out_word == 10'h04D, "R11 word", out_word, 10'h04D);
      end
    join
    wait_ticks(20);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_plain();
    t_seven();
    t_eight_par();
    t_nine();
    t_glitch();
    t_framing();
    t_stop();
    t_enable();
    t_loop();
    t_backpressure();
    t_timing();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    end
    $finish;
  end

endmodule